// File: doc/BRIEF.md
# Period-Steered PWM Oscillator Control

This block converts a periodic phase-error sample into a single pulse-width-modulated line. After an RC filter and amplifier, the line steers a voltage-controlled crystal oscillator. In the default steering mode the sample sets the length of each PWM cycle, and the high time stays at a fixed configured value. A larger sample therefore stretches the cycle and lowers the average level, which pulls a fast oscillator down. Because the sample moves the period and not the duty, the full 8-bit sample range maps to a low band of average levels with fine resolution.

A mode pin selects a second scheme. In that scheme the cycle length is a fixed parameter and the high time is the bitwise inverse of the sample. Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is high at all times outside reset, and every beat presented with `s_valid` is taken. When several beats arrive within one PWM cycle, the most recent one wins. A new sample, a new high-time configuration and a new mode take effect only when the next PWM cycle starts, so a change never produces a truncated or glitched pulse. Time is counted in ticks of an internal prescaler, which divides the clock by `TICK_DIV` (default 1, one tick per clock).

Top module: `pwm_period_mod`

## Requirements
- R1: While `rst_n` is low, `pwm_out` and `s_ready` are both low from the clock edge after reset is sampled.
- R2: In period mode (`mode_sel`=0), until the first sample is accepted, each PWM cycle lasts 256 ticks, the same as a sample of 255.
- R3: In period mode with sample value S and high time H, where 0 < H < S, each cycle lasts S+1 ticks. `pwm_out` is high for the first H ticks and low for the rest.
- R4: With a nonzero high time H and a cycle value P where H >= P, `pwm_out` stays high continuously. This includes the boundary H = P.
- R5: A high time of 0 holds `pwm_out` low continuously.
- R6: A sample of 255 gives a 256-tick cycle, the longest one and the lowest average for a given high time.
- R7: A sample accepted partway through a cycle changes neither the length nor the high time of that cycle. It applies from the next cycle start.
- R8: When two samples are accepted within one cycle, only the later one sets the following cycle.
- R9: In complement mode (`mode_sel`=1), each cycle lasts FIXED_PERIOD+1 ticks (256 by default) and the high time is ~S. A sample of 8'hFF therefore gives a constantly low output.
- R10: Changes to `hi_cfg` and `mode_sel` made partway through a cycle take effect only at the next cycle start.
- R11: `s_ready` is high on every cycle after the first clock edge following reset release, and every valid beat is accepted without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat ready, high outside reset |
| s_data | input | 8 | Phase-error sample |
| hi_cfg | input | 8 | Fixed high time in ticks, used in period mode |
| mode_sel | input | 1 | 0: sample sets the period; 1: inverted sample sets the high time |
| pwm_out | output | 1 | PWM control line |

## Verification
If the cycle counter or the active period register holds a wrong value, the distance between successive rising edges of `pwm_out` is wrong within one PWM cycle. That is at most 256 ticks after the fault. A wrong active high time shows as a wrong pulse width in the same cycle. If the pending sample register is wrong, the error appears one cycle boundary later. A latching fault that lets a new value load partway through a cycle shows as a single cycle whose length or pulse width matches neither the old setting nor the new one.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;
  localparam int CTL_W = 8;

  typedef logic [CTL_W-1:0] ctl_word_t;

  typedef enum logic {
    MODE_PERIOD = 1'b0,
    MODE_COMPL  = 1'b1
  } steer_mode_e;

  typedef struct packed {
    ctl_word_t period;
    ctl_word_t high;
  } pwm_setting_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (div_cnt == LAST) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign tick = (div_cnt == LAST);
endmodule

// File: rtl/pwm_sample_latch.sv
module pwm_sample_latch
  import pwm_ctl_pkg::*;
#(
  parameter ctl_word_t RESET_VAL = '1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  ctl_word_t in_data,
  output logic      in_ready,
  output ctl_word_t pend
);
  logic rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= RESET_VAL;
    end else if (in_valid && rdy_q) begin
      pend <= in_data;
    end
  end

  assign in_ready = rdy_q;
endmodule

// File: rtl/pwm_setting_sel.sv
module pwm_setting_sel
  import pwm_ctl_pkg::*;
#(
  parameter ctl_word_t FIXED_PERIOD = '1
) (
  input  ctl_word_t    pend,
  input  ctl_word_t    hi_cfg,
  input  logic         mode_sel,
  output pwm_setting_t nxt
);
  steer_mode_e mode;

  assign mode = steer_mode_e'(mode_sel);

  always_comb begin
    case (mode)
      MODE_COMPL: begin
        nxt.period = FIXED_PERIOD;
        nxt.high   = ~pend;
      end
      default: begin
        nxt.period = pend;
        nxt.high   = hi_cfg;
      end
    endcase
  end
endmodule

// File: rtl/pwm_cycle_core.sv
module pwm_cycle_core
  import pwm_ctl_pkg::*;
#(
  parameter ctl_word_t RESET_PERIOD = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  pwm_setting_t nxt,
  output logic         pwm_out,
  output ctl_word_t    cnt,
  output ctl_word_t    act_period,
  output ctl_word_t    act_high
);
  logic at_end;

  assign at_end = (cnt == act_period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= RESET_PERIOD;
      act_period <= RESET_PERIOD;
      act_high   <= '0;
    end else if (tick) begin
      if (at_end) begin
        cnt        <= '0;
        act_period <= nxt.period;
        act_high   <= nxt.high;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (act_high == '0) begin
      pwm_out = 1'b0;
    end else if (act_high >= act_period) begin
      pwm_out = 1'b1;
    end else begin
      pwm_out = (cnt < act_high);
    end
  end
endmodule

// File: rtl/pwm_period_mod.sv
module pwm_period_mod
  import pwm_ctl_pkg::*;
#(
  parameter int        TICK_DIV     = 1,
  parameter ctl_word_t FIXED_PERIOD = '1,
  parameter ctl_word_t RESET_PERIOD = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [CTL_W-1:0]       s_data,
  input  logic [CTL_W-1:0]       hi_cfg,
  input  logic                   mode_sel,
  output logic                   pwm_out
);
  logic         tick;
  ctl_word_t    pend;
  pwm_setting_t nxt;
  ctl_word_t    cyc_cnt;
  ctl_word_t    act_period;
  ctl_word_t    act_high;

  pwm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  pwm_sample_latch #(.RESET_VAL(RESET_PERIOD)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_valid),
    .in_data  (s_data),
    .in_ready (s_ready),
    .pend     (pend)
  );

  pwm_setting_sel #(.FIXED_PERIOD(FIXED_PERIOD)) u_sel (
    .pend     (pend),
    .hi_cfg   (hi_cfg),
    .mode_sel (mode_sel),
    .nxt      (nxt)
  );

  pwm_cycle_core #(.RESET_PERIOD(RESET_PERIOD)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .nxt        (nxt),
    .pwm_out    (pwm_out),
    .cnt        (cyc_cnt),
    .act_period (act_period),
    .act_high   (act_high)
  );
endmodule

// File: rtl/pwm_period_mod_chk.sv
module pwm_period_mod_chk
  import pwm_ctl_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      s_ready,
  input logic      pwm_out,
  input ctl_word_t cnt,
  input ctl_word_t act_period,
  input ctl_word_t act_high
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!pwm_out && !s_ready));

  // R11
  ready_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_period);

  // R7
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(act_period));

  // R10
  high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(act_high));

  // R3
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> (cnt == '0));

  // R3
  fall_at_high_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_out) |-> ((cnt == act_high) || (cnt == '0)));
endmodule

bind pwm_period_mod pwm_period_mod_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_ready    (s_ready),
  .pwm_out    (pwm_out),
  .cnt        (cyc_cnt),
  .act_period (act_period),
  .act_high   (act_high)
);

// File: tb/pwm_period_mod_test.sv
module pwm_period_mod_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'd0;
  logic [7:0] hi_cfg = 8'd0;
  logic       mode_sel = 1'b0;
  logic       s_ready;
  logic       pwm_out;

  always #5 clk = ~clk;

  pwm_period_mod uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_data   (s_data),
    .hi_cfg   (hi_cfg),
    .mode_sel (mode_sel),
    .pwm_out  (pwm_out)
  );

  typedef struct {
    int    hi;
    int    len;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  event rise_ev;

  task automatic note(input bit ok, input string tag, input string what,
                      input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: measures each PWM cycle from rising edge to rising edge
  initial begin
    bit   prev;
    bit   armed;
    int   len;
    int   hi;
    exp_t e;
    prev = 1'b0; armed = 1'b0; len = 0; hi = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev = 1'b0; armed = 1'b0; len = 0; hi = 0;
      end else begin
        if (pwm_out && !prev) begin
          if (armed) begin
            e = exp_q.pop_front();
            checks++;
            if (hi != e.hi || len != e.len) begin
              fails++;
              $display("FAIL %s cycle actual high=%0d len=%0d expected high=%0d len=%0d",
                       e.tag, hi, len, e.hi, e.len);
            end
          end
          armed = (exp_q.size() > 0);
          len = 0;
          hi = 0;
          -> rise_ev;
        end
        len++;
        if (pwm_out) hi++;
        prev = pwm_out;
      end
    end
  end

  task automatic send(input logic [7:0] v);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = v;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic expect_cycle(input int h, input int l, input string tag);
    exp_t e;
    @(rise_ev);
    e.hi = h; e.len = l; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic hold_level(input logic v, input int n, input string tag);
    int bad;
    bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out !== v) bad++;
    end
    note(bad == 0, tag, "steady level mismatches", bad, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=complete");
      finish_run();
    end
  end

  initial begin
    exp_t e;
    // R1: quiet during reset
    repeat (3) @(negedge clk);
    note(pwm_out === 1'b0, "R1", "pwm_out in reset", int'(pwm_out), 0);
    note(s_ready === 1'b0, "R1", "s_ready in reset", int'(s_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11: ready after reset
    note(s_ready === 1'b1, "R11", "s_ready after reset", int'(s_ready), 1);

    // R5: zero high time keeps output low
    hold_level(1'b0, 600, "R5");

    // R2: default 256-tick cycle before any sample
    hi_cfg = 8'd10;
    expect_cycle(10, 256, "R2");

    // R3: sample sets period
    send(8'd99);
    expect_cycle(10, 100, "R3");
    send(8'd150);
    expect_cycle(10, 151, "R3");
    send(8'd99);
    expect_cycle(10, 100, "R3");

    // R7 and R10: mid-cycle changes do not touch the running cycle
    e.hi = 10; e.len = 100; e.tag = "R7";
    exp_q.push_back(e);
    @(rise_ev);
    repeat (5) @(negedge clk);
    hi_cfg = 8'd40;
    send(8'd119);
    wait (exp_q.size() == 0);
    expect_cycle(40, 120, "R10");

    // R8: later of two samples wins
    @(rise_ev);
    send(8'd30);
    send(8'd60);
    expect_cycle(40, 61, "R8");

    // R4: high time equal to period value holds output high
    hi_cfg = 8'd60;
    repeat (150) @(negedge clk);
    hold_level(1'b1, 200, "R4");

    // R3 boundary: high time one below period value
    hi_cfg = 8'd59;
    expect_cycle(59, 61, "R3");

    // R6: full-scale sample gives the longest cycle
    hi_cfg = 8'd10;
    send(8'd255);
    expect_cycle(10, 256, "R6");

    // R9: complement mode
    mode_sel = 1'b1;
    send(8'h0F);
    expect_cycle(240, 256, "R9");
    send(8'hF0);
    expect_cycle(15, 256, "R9");
    send(8'hFF);
    repeat (300) @(negedge clk);
    hold_level(1'b0, 600, "R9");

    done = 1'b1;
    finish_run();
  end
endmodule